// File: doc/BRIEF.md
# Two-Window I2C Register Port

This block is an I2C target that lets a bus controller read and write a small bank of byte registers. The controller sends a START, a 7-bit device address and a direction bit. After that come bytes that either load an internal pointer and fill registers, or fetch register contents. The device address is fixed except for its lowest bit, which comes from a strap pin. The block watches the bus through a synchronizer on its own clock and pulls SDA low through an open-drain enable. It never holds SCL.

The pointer byte carries an auto-step flag in its top bit and a register address in its lower seven bits. When the flag is set, the pointer moves on after each data byte within one of two separate windows, 01h..08h and 09h..11h. It wraps at the top of each window and never moves from one window into the other. When the flag is clear, every byte goes to the same register. The pointer keeps its value from one transfer to the next, so a later read starts where the last access left off. The bus pins are bit-serial with no valid/ready flow control. Flow control is the I2C acknowledge: a controller NACK on a read byte stops further output.

Top module: `i2c_regport`

## Requirements
- R1: The block answers address byte {6'b001100, addr_lsb, rw} (bit 0 sent last is rw) by pulling SDA low during the ninth clock. Any other address gets no acknowledge.
- R2: After an address that does not match, sda_oe stays low until the next START, whatever bytes follow.
- R3: In a write (rw=0), the first byte after the address loads the pointer, and each later byte is stored in the register the pointer selects. Every byte received in a matched write is acknowledged.
- R4: Bit 7 of the pointer byte enables auto-step. With bit 7 at 0, all data bytes of the transfer go to, or come from, the same register.
- R5: With auto-step on, the pointer moves 01h..08h in order and wraps from 08h to 01h, never reaching 09h.
- R6: With auto-step on, the pointer moves 09h..11h in order and wraps from 11h to 09h.
- R7: Pointer values outside 01h..11h (00h, 12h..7Fh) read as 00h, discard writes and do not step.
- R8: In a read (rw=1), the register at the pointer is sent MSB first, starting right after the address acknowledge. Another byte follows each controller ACK. A controller NACK releases SDA until STOP or START.
- R9: A STOP returns the block to idle. A START, including a repeated START inside a transfer, restarts the address phase. The pointer survives both.
- R10: sda_oe is low after reset and while idle, and it changes only after a falling SCL edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus pins are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| addr_lsb | input | 1 | Strap that sets bit 0 of the device address |
| sda_oe | output | 1 | When high, the pad pulls SDA low |

## Verification
Two things fall on the same system cycle at the end of each written data byte: the store into the addressed register and the step of the pointer. The store must use the address from before the step. This is provoked by writing bursts that cross 08h and 11h, so the store and the wrap land together. It is judged by reading the whole window back afterwards through a repeated START. In the same way, each read byte ends with a pointer step followed by a fetch at the new address. A wrong ordering shows up as a byte from the neighbouring register in the scoreboard.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_MAP, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK, ST_IGNORE
  } link_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int A_LO = 1,
  parameter int A_HI = 8,
  parameter int B_LO = 9,
  parameter int B_HI = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [6:0] waddr,
  input  logic [7:0] wdata,
  input  logic [6:0] raddr,
  output logic [7:0] rdata
);
  localparam int NA   = A_HI - A_LO + 1;
  localparam int NB   = B_HI - B_LO + 1;
  localparam int NREG = NA + NB;

  logic [NREG-1:0][7:0] mem;
  logic [NREG-1:0]      hit_w, hit_r;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    localparam int RA = (g < NA) ? (A_LO + g) : (B_LO + g - NA);
    assign hit_w[g] = (waddr == 7'(RA));
    assign hit_r[g] = (raddr == 7'(RA));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem <= '0;
    else begin
      for (int i = 0; i < NREG; i++)
        if (we && hit_w[i]) mem[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (hit_r[i]) rdata = rdata | mem[i];
  end

  // R7: an out-of-window write leaves every register untouched
  p_oob_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !(|hit_w)) |=> $stable(mem));
  // R7: an out-of-window pointer reads as zero
  p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit_r) |-> (rdata == 8'h00));
endmodule

// File: rtl/i2c_link.sv
module i2c_link
  import i2c_regport_pkg::*;
#(
  parameter logic [5:0] DEV_HI = 6'b001100,
  parameter int A_LO = 1,
  parameter int A_HI = 8,
  parameter int B_LO = 9,
  parameter int B_HI = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_lsb,
  input  logic [7:0] rdata,
  output logic       sda_oe,
  output logic       we,
  output logic [6:0] waddr,
  output logic [7:0] wdata,
  output logic [6:0] raddr
);
  link_st_e   st;
  logic [7:0] sh, tx, ptr;
  logic [2:0] cnt;
  logic       byte_done, rw, map_seen, mack;
  logic       ptr_step;
  logic [7:0] ptr_nxt;

  function automatic logic [6:0] win_step(input logic [6:0] a);
    if (a == 7'(A_HI)) return 7'(A_LO);
    if (a == 7'(B_HI)) return 7'(B_LO);
    if ((a >= 7'(A_LO) && a < 7'(A_HI)) || (a >= 7'(B_LO) && a < 7'(B_HI)))
      return a + 7'd1;
    return a;
  endfunction

  assign ptr_nxt  = ptr[7] ? {1'b1, win_step(ptr[6:0])} : ptr;
  assign ptr_step = !start_det && !stop_det && scl_fall && byte_done &&
                    (st == ST_WDATA || st == ST_RDATA);
  assign raddr    = ptr[6:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; tx <= '0; ptr <= '0; cnt <= '0;
      byte_done <= 1'b0; rw <= 1'b0; map_seen <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; we <= 1'b0; waddr <= '0; wdata <= '0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0; byte_done <= 1'b0;
        sda_oe <= 1'b0; map_seen <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_MAP, ST_WDATA: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              byte_done <= (cnt == 3'd7);
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == {DEV_HI, addr_lsb}) begin
                  rw <= sh[0]; sda_oe <= 1'b1; st <= ST_ACK;
                end else st <= ST_IGNORE;
              end else if (st == ST_MAP) begin
                ptr <= sh; map_seen <= 1'b1; sda_oe <= 1'b1; st <= ST_ACK;
              end else begin
                we <= 1'b1; waddr <= ptr[6:0]; wdata <= sh;
                ptr <= ptr_nxt; sda_oe <= 1'b1; st <= ST_ACK;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            cnt <= '0; byte_done <= 1'b0;
            if (rw) begin
              tx <= rdata; sda_oe <= ~rdata[7]; st <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0; st <= map_seen ? ST_WDATA : ST_MAP;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
              byte_done <= (cnt == 3'd7);
            end else if (scl_fall) begin
              if (byte_done) begin
                byte_done <= 1'b0; sda_oe <= 1'b0;
                ptr <= ptr_nxt; st <= ST_RACK;
              end else begin
                tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                tx <= rdata; sda_oe <= ~rdata[7]; cnt <= '0; st <= ST_RDATA;
              end else st <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: idle bus is never pulled
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  // R10: the pull changes only after a falling SCL, START or STOP
  p_oe_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !start_det && !stop_det) |=> $stable(sda_oe));
  // R2: an ignored transfer never pulls SDA
  p_mismatch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_oe);
  // R1: the acknowledge slot is driven low
  p_ack_driven_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK) |-> sda_oe);
  // R9: START restarts the address phase
  p_start_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR));
  // R9: STOP returns to idle
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (st == ST_IDLE));
  // R4: with auto-step off the pointer holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && !ptr[7]) |=> $stable(ptr));
  // R5: stepping inside the low window stays inside it
  p_win_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr[7] && ptr[6:0] >= 7'(A_LO) && ptr[6:0] <= 7'(A_HI))
      |=> (ptr[6:0] >= 7'(A_LO) && ptr[6:0] <= 7'(A_HI)));
  // R6: stepping inside the high window stays inside it
  p_win_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr[7] && ptr[6:0] >= 7'(B_LO) && ptr[6:0] <= 7'(B_HI))
      |=> (ptr[6:0] >= 7'(B_LO) && ptr[6:0] <= 7'(B_HI)));
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [5:0] DEV_HI      = 6'b001100,
  parameter int         SYNC_STAGES = 2,
  parameter int         A_LO        = 1,
  parameter int         A_HI        = 8,
  parameter int         B_LO        = 9,
  parameter int         B_HI        = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_lsb,
  output logic sda_oe
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det, we;
  logic [6:0] waddr, raddr;
  logic [7:0] wdata, rdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_link #(.DEV_HI(DEV_HI), .A_LO(A_LO), .A_HI(A_HI), .B_LO(B_LO), .B_HI(B_HI)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_lsb(addr_lsb), .rdata(rdata), .sda_oe(sda_oe), .we(we),
    .waddr(waddr), .wdata(wdata), .raddr(raddr)
  );

  i2c_regbank #(.A_LO(A_LO), .A_HI(A_HI), .B_LO(B_LO), .B_HI(B_HI)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/i2c_regport_test.sv
`timescale 1ns/1ps
module i2c_regport_test;
  localparam int Q = 100;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, strap = 1'b0;
  logic sda_oe, sda_bus;
  logic watch = 1'b0, seen_pull = 1'b0;

  assign sda_bus = ~(sda_oe | m_low);
  always #2.5 clk = ~clk;

  i2c_regport uut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
                   .addr_lsb(strap), .sda_oe(sda_oe));

  typedef struct { logic [7:0] v; string req; } item_t;
  item_t expq[$];
  int checks = 0, fails = 0;
  logic [7:0] model [0:127];
  logic [7:0] mptr = 8'h00;
  logic [7:0] obs_v;
  event obs_ev;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the expected item for each observed bus result
  always begin
    @(obs_ev);
    if (expq.size() == 0) chk("SCOREBOARD", obs_v, 8'hxx);
    else begin
      item_t it;
      it = expq.pop_front();
      chk(it.req, obs_v, it.v);
    end
  end

  always @(posedge clk) if (watch && sda_oe) seen_pull <= 1'b1;

  task automatic observe(input logic [7:0] v);
    obs_v = v; ->obs_ev; #1;
  endtask

  function automatic bit in_win(input logic [6:0] a);
    return (a >= 7'd1 && a <= 7'd17);
  endfunction

  function automatic logic [7:0] madv(input logic [7:0] p);
    logic [6:0] a = p[6:0];
    if (!p[7]) return p;
    if (a == 7'd8) return 8'h81;
    if (a == 7'd17) return 8'h89;
    if ((a >= 7'd1 && a < 7'd8) || (a >= 7'd9 && a < 7'd17)) return {1'b1, a + 7'd1};
    return p;
  endfunction

  task automatic bus_start();
    m_low = 0; #(Q); scl = 1; #(Q); m_low = 1; #(Q); scl = 0; #(Q);
  endtask
  task automatic bus_stop();
    m_low = 1; #(Q); scl = 1; #(Q); m_low = 0; #(Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack_lvl);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; #(Q); scl = 1; #(2*Q); scl = 0; #(Q);
    end
    m_low = 0; #(Q); scl = 1; #(Q); ack_lvl = sda_bus; #(Q); scl = 0; #(Q);
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] d);
    m_low = 0;
    for (int i = 0; i < 8; i++) begin
      #(Q); scl = 1; #(Q); d = {d[6:0], sda_bus}; #(Q); scl = 0; #(Q);
    end
    m_low = mack; #(Q); scl = 1; #(2*Q); scl = 0; #(Q); m_low = 0;
  endtask

  // ack expectation: bus level 0 = acknowledged, 1 = not
  task automatic put_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    expq.push_back('{v: {7'd0, !exp_ack}, req: req});
    send_byte(b, a);
    observe({7'd0, a});
  endtask

  task automatic begin_write(input logic [7:0] map, input string req);
    bus_start();
    put_byte({6'b001100, strap, 1'b0}, 1'b1, "R1");
    put_byte(map, 1'b1, req);
    mptr = map;
  endtask
  task automatic wbyte(input logic [7:0] v, input string req);
    put_byte(v, 1'b1, req);
    if (in_win(mptr[6:0])) model[mptr[6:0]] = v;
    mptr = madv(mptr);
  endtask
  task automatic begin_read(input string req);
    bus_start();
    put_byte({6'b001100, strap, 1'b1}, 1'b1, req);
  endtask
  task automatic rbyte(input logic mack, input string req);
    logic [7:0] d;
    expq.push_back('{v: in_win(mptr[6:0]) ? model[mptr[6:0]] : 8'h00, req: req});
    recv_byte(mack, d);
    observe(d);
    mptr = madv(mptr);
  endtask
  task automatic check_released(input string req);
    logic lvl;
    m_low = 0; #(Q); scl = 1; #(Q); lvl = sda_bus; #(Q); scl = 0; #(Q);
    chk(req, {7'd0, lvl}, 8'h01);
  endtask

  initial begin
    #(150000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    #(100); rst_n = 1; #(100);
    chk("R10 reset release", {7'd0, sda_oe}, 8'h00);

    // R3/R5: burst across 08h wraps to 01h
    begin_write(8'h81, "R3");
    for (int i = 1; i <= 9; i++) wbyte(8'(i * 17), "R5");
    bus_stop();

    // R9/R8: repeated start then read window back, NACK last
    begin_write(8'h81, "R9");
    begin_read("R9");
    for (int i = 0; i < 9; i++) rbyte(i != 8, "R8");
    check_released("R8 nack release");
    bus_stop();

    // R5: write from 08h goes to 01h, 09h untouched
    begin_write(8'h88, "R5");
    wbyte(8'hA1, "R5"); wbyte(8'hA2, "R5"); wbyte(8'hA3, "R5");
    bus_stop();
    begin_write(8'h87, "R5");
    begin_read("R5");
    for (int i = 0; i < 5; i++) rbyte(i != 4, "R5");
    bus_stop();
    begin_write(8'h09, "R5");
    begin_read("R5");
    rbyte(1'b0, "R5 reg09 untouched");
    bus_stop();

    // R6: high window wraps 11h -> 09h
    begin_write(8'h90, "R6");
    wbyte(8'hB1, "R6"); wbyte(8'hB2, "R6"); wbyte(8'hB3, "R6");
    bus_stop();
    begin_write(8'h8F, "R6");
    begin_read("R6");
    for (int i = 0; i < 5; i++) rbyte(i != 4, "R6");
    bus_stop();

    // R4: no auto-step
    begin_write(8'h05, "R4");
    wbyte(8'hC1, "R4"); wbyte(8'hC2, "R4"); wbyte(8'hC3, "R4");
    begin_read("R4");
    for (int i = 0; i < 3; i++) rbyte(i != 2, "R4");
    bus_stop();

    // R7: outside the windows
    begin_write(8'h94, "R7");
    wbyte(8'h5A, "R7"); wbyte(8'h5B, "R7");
    begin_read("R7");
    rbyte(1'b1, "R7"); rbyte(1'b0, "R7");
    bus_stop();
    begin_write(8'h80, "R7");
    wbyte(8'h66, "R7");
    begin_read("R7");
    rbyte(1'b0, "R7 reg00");
    bus_stop();

    // R2: wrong address, later bytes ignored
    watch = 1;
    bus_start();
    put_byte({6'b001101, 1'b0, 1'b0}, 1'b0, "R2");
    put_byte(8'h81, 1'b0, "R2");
    put_byte(8'hEE, 1'b0, "R2");
    bus_stop();
    #(20); watch = 0;
    chk("R2 no pull", {7'd0, seen_pull}, 8'h00);
    begin_write(8'h81, "R2");
    begin_read("R2");
    rbyte(1'b1, "R2 reg01 intact"); rbyte(1'b0, "R2 reg02 intact");
    bus_stop();

    // R1: strap moves the address
    strap = 1;
    bus_start();
    put_byte({6'b001100, 1'b0, 1'b0}, 1'b0, "R1 old address");
    bus_stop();
    begin_write(8'h83, "R1");
    wbyte(8'hD4, "R1");
    bus_stop();

    // R9: pointer survives STOP; read with no pointer byte
    begin_read("R9");
    rbyte(1'b1, "R9"); rbyte(1'b0, "R9");
    bus_stop();
    begin_write(8'h83, "R1");
    begin_read("R1");
    rbyte(1'b0, "R1 strap write");
    bus_stop();

    #(Q);
    chk("R10 idle release", {7'd0, sda_oe}, 8'h00);
    chk("SCOREBOARD drained", 8'(expq.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule